// File: doc/BRIEF.md
# Serial DAC Command Interface

This block is the digital front end of a single-channel serial digital-to-analog converter. A host shifts 24-bit command words in on a serial data line, clocked by a serial clock, while an active-low select/load line is held low. Raising the select/load line executes the last received word. The block keeps an input register and a DAC register, tracks whether the converter is powered down, and honours an active-low asynchronous load pin. It drives out the DAC register code, a powered-down flag and a serial output that repeats the incoming stream 24 clocks later, so several devices can share one select line and be chained.

All pins are sampled on a fast system clock. Serial clock and select edges are detected by comparing each pin with its value one system clock earlier. The resolution is a parameter of 12, 14 or 16 bits.

Top module: `serial_dac_if`

## Requirements
- R1: Bits are taken from `sdi` on each rising `sck` edge while `csLdN` is low, most significant bit first. When more than 24 bits arrive in one select window, only the last 24 form the frame. Frame bits 23:20 hold the command and bits 15:0 hold the data field.
- R2: The data field is left-justified. The code is data bits 15 down to 16-RES, and the lower data bits are ignored.
- R3: `dacCode` and `powerDown` do not change while `csLdN` is low, except that `powerDown` may be cleared as R11 describes. The frame is executed on the rising edge of `csLdN`.
- R4: Command 0000 loads the code into the input register and leaves `dacCode` unchanged.
- R5: Command 0001 copies the input register to `dacCode`.
- R6: Command 0011 loads the input register and sets `dacCode` to the new code in the same step.
- R7: Command 0100 sets `powerDown` and ignores the data field. It leaves the input register and `dacCode` unchanged. A later 0000 write does not clear `powerDown`.
- R8: Command 1111, and every code not listed in R4 to R7, changes neither register and not `powerDown`.
- R9: Any update of `dacCode` clears `powerDown`.
- R10: While `csLdN` is high, a low `ldacN` copies the input register to `dacCode` and clears `powerDown`.
- R11: While `csLdN` is low, a low `ldacN` clears `powerDown` without changing `dacCode`.
- R12: If `ldacN` is low at the rising edge of `csLdN`, the frame's command is executed and `dacCode` is then updated from the resulting input register. `powerDown` ends up clear even when the command was 0100.
- R13: After each falling `sck` edge while `csLdN` is low, `sdo` shows the bit received 23 rising edges before the latest one. `sdo` changes at no other time.
- R14: After reset, `dacCode` is 0, `powerDown` is 0 and `sdo` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample all pins |
| rstN | input | 1 | Active-low synchronous reset |
| sck | input | 1 | Serial clock |
| csLdN | input | 1 | Active-low select; its rising edge executes the frame |
| sdi | input | 1 | Serial data in |
| ldacN | input | 1 | Active-low asynchronous DAC load |
| dacCode | output | RES | DAC register contents |
| powerDown | output | 1 | High while the converter is powered down |
| sdo | output | 1 | Serial data out for chaining |

## Verification
The bench targets the cases where the load pin and the select line interact. A load pulse inside a frame must wake the converter but keep the output frozen; a design that updated it there would show the pending input code too early. A load held low across the select rising edge must override a power-down command, and a design that let the command win would report powered down. Stray codes and 1111 must leave the input register untouched, which a later copy command reveals. An oversized 48-bit window must execute only its last 24 bits, and `sdo` must replay the first 24. A design that kept the first word, or that shifted `sdo` on the wrong edge, fails there.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CMD_BITS   = 4;
  localparam int DATA_BITS  = 16;

  typedef enum logic [CMD_BITS-1:0] {
    CMD_WRITE        = 4'b0000,
    CMD_UPDATE       = 4'b0001,
    CMD_WRITE_UPDATE = 4'b0011,
    CMD_POWER_DOWN   = 4'b0100,
    CMD_NOP          = 4'b1111
  } cmd_e;

  typedef struct packed {
    logic shiftEn;
    logic sdoEn;
    logic loadInput;
    logic updateDac;
    logic setPd;
    logic clearPd;
  } strobe_t;
endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                sck,
  input  logic                csLdN,
  input  logic                ldacN,
  input  logic [CMD_BITS-1:0] cmdField,
  output strobe_t             stb
);
  logic sckPrev, csPrev;
  logic csRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sckPrev <= 1'b0;
      csPrev  <= 1'b1;
    end else begin
      sckPrev <= sck;
      csPrev  <= csLdN;
    end
  end

  always_comb begin
    stb        = '0;
    csRise     = csLdN & ~csPrev;
    stb.shiftEn = ~csLdN & sck & ~sckPrev;
    stb.sdoEn   = ~csLdN & ~sck & sckPrev;
    if (csRise) begin
      case (cmd_e'(cmdField))
        CMD_WRITE:        stb.loadInput = 1'b1;
        CMD_UPDATE:       stb.updateDac = 1'b1;
        CMD_WRITE_UPDATE: begin
          stb.loadInput = 1'b1;
          stb.updateDac = 1'b1;
        end
        CMD_POWER_DOWN:   stb.setPd = 1'b1;
        default:          ;
      endcase
      if (!ldacN) begin
        stb.updateDac = 1'b1;
        stb.setPd     = 1'b0;
      end
    end else if (csLdN && !ldacN) begin
      stb.updateDac = 1'b1;
    end
    if (!csLdN && !ldacN) stb.clearPd = 1'b1;
  end
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sdi,
  input  strobe_t             stb,
  output logic [CMD_BITS-1:0] cmdField,
  output logic [RES-1:0]      dacCode,
  output logic                powerDown,
  output logic                sdo
);
  localparam int CODE_TOP = DATA_BITS - 1;

  logic [FRAME_BITS-1:0] shReg;
  logic [RES-1:0]        inputReg;
  logic [RES-1:0]        newCode;
  logic [RES-1:0]        nextInput;

  assign cmdField  = shReg[FRAME_BITS-1 -: CMD_BITS];
  assign newCode   = shReg[CODE_TOP -: RES];
  assign nextInput = stb.loadInput ? newCode : inputReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg     <= '0;
      sdo       <= 1'b0;
      inputReg  <= '0;
      dacCode   <= '0;
      powerDown <= 1'b0;
    end else begin
      if (stb.shiftEn) shReg <= {shReg[FRAME_BITS-2:0], sdi};
      if (stb.sdoEn)   sdo   <= shReg[FRAME_BITS-1];
      inputReg <= nextInput;
      if (stb.updateDac) dacCode <= nextInput;
      if (stb.setPd)
        powerDown <= 1'b1;
      else if (stb.updateDac || stb.clearPd)
        powerDown <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_dac_if.sv
module serial_dac_if
  import dacif_pkg::*;
#(
  parameter int RES = 12
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           sck,
  input  logic           csLdN,
  input  logic           sdi,
  input  logic           ldacN,
  output logic [RES-1:0] dacCode,
  output logic           powerDown,
  output logic           sdo
);
  strobe_t             stb;
  logic [CMD_BITS-1:0] cmdField;

  dacif_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .sck      (sck),
    .csLdN    (csLdN),
    .ldacN    (ldacN),
    .cmdField (cmdField),
    .stb      (stb)
  );

  dacif_datapath #(.RES(RES)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .sdi       (sdi),
    .stb       (stb),
    .cmdField  (cmdField),
    .dacCode   (dacCode),
    .powerDown (powerDown),
    .sdo       (sdo)
  );
endmodule

// File: rtl/dacif_checker.sv
module dacif_checker #(
  parameter int RES = 12
) (
  input logic           clk,
  input logic           rstN,
  input logic           sck,
  input logic           csLdN,
  input logic           ldacN,
  input logic [RES-1:0] dacCode,
  input logic           powerDown,
  input logic           sdo,
  input logic [3:0]     cmdField
);
  logic csSeen, sckSeen;
  logic csRiseC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSeen  <= 1'b1;
      sckSeen <= 1'b0;
    end else begin
      csSeen  <= csLdN;
      sckSeen <= sck;
    end
  end

  assign csRiseC = csLdN && !csSeen;

  assert_nop_stable_R8: assert property (@(posedge clk) disable iff (!rstN)
    (csRiseC && ldacN && cmdField == 4'b1111) |=> ($stable(dacCode) && $stable(powerDown)));

  assert_pd_entry_R7: assert property (@(posedge clk) disable iff (!rstN)
    (csRiseC && ldacN && cmdField == 4'b0100) |=> (powerDown && $stable(dacCode)));

  assert_frame_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!csLdN) |=> $stable(dacCode));

  assert_wake_in_frame_R11: assert property (@(posedge clk) disable iff (!rstN)
    (!csLdN && !ldacN) |=> !powerDown);

  assert_level_load_R10: assert property (@(posedge clk) disable iff (!rstN)
    (csLdN && !ldacN) |=> !powerDown);

  assert_sdo_edge_R13: assert property (@(posedge clk) disable iff (!rstN)
    !(sckSeen && !sck && !csLdN) |=> $stable(sdo));
endmodule

bind serial_dac_if dacif_checker #(.RES(RES)) u_check (.*);

// File: tb/sim_serial_dac_if.sv
`timescale 1ns/1ps
module sim_serial_dac_if;
  localparam int RES = 12;

  logic clk = 1'b0, rstN = 1'b0, sck = 1'b0, csLdN = 1'b1, sdi = 1'b0, ldacN = 1'b1;
  logic [RES-1:0] dacCode;
  logic powerDown, sdo;

  serial_dac_if #(.RES(RES)) u0 (
    .clk(clk), .rstN(rstN), .sck(sck), .csLdN(csLdN), .sdi(sdi), .ldacN(ldacN),
    .dacCode(dacCode), .powerDown(powerDown), .sdo(sdo)
  );

  always #2 clk = ~clk;

  int errors = 0, checks = 0;

  typedef struct {
    string          req;
    logic [RES-1:0] dac;
    logic           pd;
  } exp_t;

  exp_t expQ[$];
  logic history[$];
  event checkEv;

  function automatic void check(string req, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expectState(string req, logic [RES-1:0] d, logic p);
    exp_t e;
    e.req = req; e.dac = d; e.pd = p;
    expQ.push_back(e);
    idle(3);
    ->checkEv;
    idle(1);
  endtask

  // monitor: pops expected items and compares with the ports
  initial begin
    forever begin
      exp_t e;
      @(checkEv);
      if (expQ.size() > 0) begin
        e = expQ.pop_front();
        check(e.req, "dacCode", int'(dacCode), int'(e.dac));
        check(e.req, "powerDown", int'(powerDown), int'(e.pd));
      end
    end
  end

  function automatic logic [RES-1:0] code(logic [15:0] d);
    return d[15 -: RES];   // R2 left-justified
  endfunction

  task automatic shiftBit(logic b);
    @(negedge clk) sdi = b;
    idle(1); sck = 1'b1;
    idle(2); sck = 1'b0;
    idle(2);
    history.push_back(b);
    if (history.size() >= 24)
      check("R13", "sdo", int'(sdo), int'(history[history.size()-24]));
  endtask

  task automatic sendWord(logic [3:0] c, logic [15:0] d);
    logic [23:0] w;
    w = {c, 4'h0, d};
    for (int i = 23; i >= 0; i--) shiftBit(w[i]);
  endtask

  task automatic csLow();
    @(negedge clk) csLdN = 1'b0;
    idle(1);
  endtask

  task automatic csHigh();
    @(negedge clk) csLdN = 1'b1;
    idle(1);
  endtask

  task automatic frame(logic [3:0] c, logic [15:0] d);
    csLow();
    sendWord(c, d);
    csHigh();
  endtask

  task automatic ldacPulse();
    @(negedge clk) ldacN = 1'b0;
    idle(2);
    ldacN = 1'b1;
    idle(1);
  endtask

  initial begin
    #(200000 * 4);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle(4);
    rstN = 1'b1;
    expectState("R14", '0, 1'b0);
    check("R14", "sdo", int'(sdo), 0);

    frame(4'b0000, 16'h5A50);
    expectState("R4", '0, 1'b0);
    frame(4'b0001, 16'h0000);
    expectState("R5", code(16'h5A50), 1'b0);

    csLow();
    sendWord(4'b0011, 16'hABC7);
    expectState("R3", code(16'h5A50), 1'b0);
    csHigh();
    expectState("R6_R2", code(16'hABC7), 1'b0);

    frame(4'b0100, 16'hFFFF);
    expectState("R7", code(16'hABC7), 1'b1);
    frame(4'b0000, 16'h4560);
    expectState("R7", code(16'hABC7), 1'b1);
    frame(4'b0001, 16'h0000);
    expectState("R9", code(16'h4560), 1'b0);

    frame(4'b1111, 16'h7770);
    expectState("R8", code(16'h4560), 1'b0);
    frame(4'b1010, 16'h8880);
    expectState("R8", code(16'h4560), 1'b0);
    frame(4'b0001, 16'h0000);
    expectState("R8", code(16'h4560), 1'b0);

    frame(4'b0000, 16'h9990);
    expectState("R4", code(16'h4560), 1'b0);
    ldacPulse();
    expectState("R10", code(16'h9990), 1'b0);
    frame(4'b0100, 16'h0000);
    expectState("R7", code(16'h9990), 1'b1);
    ldacPulse();
    expectState("R10", code(16'h9990), 1'b0);

    frame(4'b0000, 16'h2220);
    frame(4'b0100, 16'h0000);
    expectState("R7", code(16'h9990), 1'b1);
    csLow();
    ldacPulse();
    expectState("R11", code(16'h9990), 1'b0);
    sendWord(4'b1111, 16'h0000);
    csHigh();
    expectState("R11", code(16'h9990), 1'b0);

    csLow();
    sendWord(4'b0000, 16'h3330);
    @(negedge clk) ldacN = 1'b0;
    idle(1);
    csHigh();
    expectState("R12", code(16'h3330), 1'b0);
    ldacN = 1'b1;
    idle(1);

    csLow();
    sendWord(4'b0100, 16'h0000);
    @(negedge clk) ldacN = 1'b0;
    idle(1);
    csHigh();
    expectState("R12", code(16'h3330), 1'b0);
    ldacN = 1'b1;
    idle(1);

    csLow();
    sendWord(4'b0011, 16'hEEE0);
    sendWord(4'b1111, 16'h0000);
    csHigh();
    expectState("R1", code(16'h3330), 1'b0);
    csLow();
    sendWord(4'b1111, 16'h0000);
    sendWord(4'b0011, 16'h6660);
    csHigh();
    expectState("R1", code(16'h6660), 1'b0);

    idle(4);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule